// File: doc/BRIEF.md
# Bus Bridge Error Status Logger

This block sits beside a bus bridge and keeps a record of the first bus transaction that fails. When the bridge reports a failure, the block stores the bus command, a 3-bit-meaningful error code and the failing address, and raises an error flag. Any further failure that arrives while a record is held leaves that record alone and only sets a "lost" flag. Software reads the status word and the address word, then writes the status word back. Each flag bit that is set in the written value is cleared (write-one-to-clear).

While a record is held, the block drives a machine-check request to the processor, starting one clock after the flag sets. The block also sits in the response path of configuration reads. A failed read has its data replaced by all ones. The block separates the expected "no device" failure from failures that need attention.

The status word carries two derived fields. One is an origin bit that tells whether the CPU or the bus side started the failing transaction. The other is a page field that is filled only for page-table errors.

Top module: `bridge_err_status`

## Requirements
- R1: After reset, stat_word and stat_addr are zero and mchk_req is low.
- R2: An ev_valid pulse while no record is held is visible at the clock edge that samples it. stat_word bits 3:0 hold ev_cmd, bit 4 (logged) is 1, bits 11:8 hold ev_code, bits 7:6 are 0, and stat_addr holds ev_addr.
- R3: While a record is held, stat_word bit 12 is 1 when the stored code is greater than 3 (bus-initiated) and 0 for codes 0 to 3 (CPU-initiated).
- R4: stat_word bits 31:13 hold ev_addr bits 31:13 when the stored code is 5 (page-table read error) or 6 (invalid page). For every other code they are zero.
- R5: An ev_valid pulse while a record is held leaves bits 31:0 of stat_word, other than bit 5, and stat_addr unchanged. It sets bit 5 (lost).
- R6: A write with wr_data bit 4 set clears the whole record, lost bit included, and zeroes stat_word and stat_addr. A write with only bit 5 set clears just the lost bit. A write with neither bit set changes nothing.
- R7: An ev_valid pulse in the same cycle as a write that clears bit 4 is captured as a fresh record, with the lost bit 0.
- R8: mchk_req equals the logged bit (stat_word bit 4) as it was one clock earlier.
- R9: rsp_out_data equals rsp_in_data when rsp_in_fail is 0, and 32'hFFFF_FFFF when rsp_in_fail is 1.
- R10: rsp_out_alarm is 1 exactly when rsp_in_fail is 1 and rsp_in_code is not 1 (no device). A failed read with code 1 returns all ones quietly.
- R11: The response path is a valid/ready stream with no storage. rsp_out_valid follows rsp_in_valid and rsp_in_ready follows rsp_out_ready in the same cycle. A beat transfers when valid and ready are both high. Under back-pressure the source holds its beat, and the output reflects it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | One-cycle failure report from the bridge |
| ev_cmd | input | 4 | Bus command of the failing cycle |
| ev_code | input | 4 | Error code of the failing cycle |
| ev_addr | input | 32 | Address of the failing cycle |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 32 | Write value, one bits clear flags |
| stat_word | output | 32 | Status word |
| stat_addr | output | 32 | Failing address word |
| mchk_req | output | 1 | Machine-check request |
| rsp_in_valid | input | 1 | Configuration read response valid |
| rsp_in_ready | output | 1 | Response accepted from the bridge |
| rsp_in_data | input | 32 | Raw read data |
| rsp_in_fail | input | 1 | The read failed |
| rsp_in_code | input | 4 | Error code of the failed read |
| rsp_out_valid | output | 1 | Filtered response valid |
| rsp_out_ready | input | 1 | Consumer ready |
| rsp_out_data | output | 32 | Read data, all ones on failure |
| rsp_out_alarm | output | 1 | Failure other than no device |

## Verification
The assertions assume that ev_valid and wr_en are each held for one cycle per report or write. They also assume that the source of the response stream keeps rsp_in_data, rsp_in_fail and rsp_in_code stable while a beat waits for ready. The bench drives events and writes in single-cycle pulses on the falling edge. It changes response fields only between beats, and it holds them across stalled cycles in its back-pressure test.

// File: rtl/bes_pkg.sv
package bes_pkg;
  localparam int STAT_W   = 32;
  localparam int CMD_LSB  = 0;
  localparam int FLAG_BIT = 4;
  localparam int LOST_BIT = 5;
  localparam int CODE_LSB = 8;
  localparam int ORIG_BIT = 12;
  localparam int PAGE_LSB = 13;
  localparam int PAGE_W   = STAT_W - PAGE_LSB;

  typedef enum logic [3:0] {
    EC_RETRY    = 4'd0,
    EC_NODEV    = 4'd1,
    EC_DPAR     = 4'd2,
    EC_TABORT   = 4'd3,
    EC_APAR     = 4'd4,
    EC_PTREAD   = 4'd5,
    EC_BADPAGE  = 4'd6,
    EC_DATA     = 4'd7
  } err_code_e;

  localparam logic [3:0] LAST_CPU_CODE = 4'd3;
endpackage

// File: rtl/bes_capture.sv
module bes_capture
  import bes_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CMD_W-1:0]  ev_cmd,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              clr_flag,
  input  logic              clr_lost,
  output logic              flag_q,
  output logic              lost_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [CODE_W-1:0] code_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              mchk_q
);
  logic held_after_write;
  logic take_new;
  logic mark_lost;

  always_comb begin
    held_after_write = flag_q & ~clr_flag;
    take_new         = ev_valid & ~held_after_write;
    mark_lost        = ev_valid & held_after_write;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      cmd_q  <= '0;
      code_q <= '0;
      addr_q <= '0;
    end else if (take_new) begin
      flag_q <= 1'b1;
      cmd_q  <= ev_cmd;
      code_q <= ev_code;
      addr_q <= ev_addr;
    end else if (clr_flag) begin
      flag_q <= 1'b0;
      cmd_q  <= '0;
      code_q <= '0;
      addr_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  lost_q <= 1'b0;
    else if (mark_lost)          lost_q <= 1'b1;
    else if (clr_flag | clr_lost) lost_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mchk_q <= 1'b0;
    else        mchk_q <= flag_q;
  end
endmodule

// File: rtl/bes_pack.sv
module bes_pack
  import bes_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 32,
  parameter int N_PAGE_CODES = 2,
  parameter logic [N_PAGE_CODES*CODE_W-1:0] PAGE_CODES = {4'd6, 4'd5}
) (
  input  logic              flag_q,
  input  logic              lost_q,
  input  logic [CMD_W-1:0]  cmd_q,
  input  logic [CODE_W-1:0] code_q,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [STAT_W-1:0] word
);
  logic [N_PAGE_CODES-1:0] hit;
  logic page_sel;
  logic origin_bus;

  for (genvar g = 0; g < N_PAGE_CODES; g++) begin : g_page_match
    assign hit[g] = (code_q == PAGE_CODES[g*CODE_W +: CODE_W]);
  end

  always_comb begin
    page_sel   = flag_q & (|hit);
    origin_bus = flag_q & (code_q > CODE_W'(LAST_CPU_CODE));
    word = '0;
    word[CMD_LSB +: CMD_W]   = cmd_q;
    word[FLAG_BIT]           = flag_q;
    word[LOST_BIT]           = lost_q;
    word[CODE_LSB +: CODE_W] = code_q;
    word[ORIG_BIT]           = origin_bus;
    if (page_sel) word[PAGE_LSB +: PAGE_W] = addr_q[PAGE_LSB +: PAGE_W];
  end
endmodule

// File: rtl/bes_cfg_fill.sv
module bes_cfg_fill
  import bes_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_fail,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_alarm
);
  always_comb begin
    out_valid = in_valid;
    in_ready  = out_ready;
    out_data  = in_fail ? {DATA_W{1'b1}} : in_data;
    out_alarm = in_fail & (in_code != CODE_W'(EC_NODEV));
  end
endmodule

// File: rtl/bridge_err_status.sv
module bridge_err_status
  import bes_pkg::*;
#(
  parameter int CMD_W  = 4,
  parameter int CODE_W = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CMD_W-1:0]  ev_cmd,
  input  logic [CODE_W-1:0] ev_code,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_word,
  output logic [ADDR_W-1:0] stat_addr,
  output logic              mchk_req,
  input  logic              rsp_in_valid,
  output logic              rsp_in_ready,
  input  logic [DATA_W-1:0] rsp_in_data,
  input  logic              rsp_in_fail,
  input  logic [CODE_W-1:0] rsp_in_code,
  output logic              rsp_out_valid,
  input  logic              rsp_out_ready,
  output logic [DATA_W-1:0] rsp_out_data,
  output logic              rsp_out_alarm
);
  logic              clr_flag, clr_lost;
  logic              flag_q, lost_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CODE_W-1:0] code_q;
  logic [ADDR_W-1:0] addr_q;

  assign clr_flag = wr_en & wr_data[FLAG_BIT];
  assign clr_lost = wr_en & wr_data[LOST_BIT];

  bes_capture #(.CMD_W(CMD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_capture (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_cmd(ev_cmd), .ev_code(ev_code), .ev_addr(ev_addr),
    .clr_flag(clr_flag), .clr_lost(clr_lost),
    .flag_q(flag_q), .lost_q(lost_q), .cmd_q(cmd_q), .code_q(code_q),
    .addr_q(addr_q), .mchk_q(mchk_req)
  );

  bes_pack #(.CMD_W(CMD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_pack (
    .flag_q(flag_q), .lost_q(lost_q), .cmd_q(cmd_q), .code_q(code_q),
    .addr_q(addr_q), .word(stat_word)
  );

  assign stat_addr = addr_q;

  bes_cfg_fill #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_fill (
    .in_valid(rsp_in_valid), .in_ready(rsp_in_ready), .in_data(rsp_in_data),
    .in_fail(rsp_in_fail), .in_code(rsp_in_code),
    .out_valid(rsp_out_valid), .out_ready(rsp_out_ready),
    .out_data(rsp_out_data), .out_alarm(rsp_out_alarm)
  );
endmodule

// File: rtl/bes_checker.sv
module bes_checker
  import bes_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic              wr_en,
  input logic [STAT_W-1:0] wr_data,
  input logic [STAT_W-1:0] stat_word,
  input logic [ADDR_W-1:0] stat_addr,
  input logic              mchk_req,
  input logic              rsp_in_valid,
  input logic              rsp_in_fail,
  input logic              rsp_out_valid,
  input logic [DATA_W-1:0] rsp_out_data
);
  assert_mchk_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mchk_req == $past(stat_word[FLAG_BIT]));

  assert_lost_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[LOST_BIT] |-> stat_word[FLAG_BIT]);

  assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[FLAG_BIT] && ev_valid && !(wr_en && wr_data[FLAG_BIT]))
    |=> (stat_word[LOST_BIT] && $stable(stat_word[31:LOST_BIT+1])
         && $stable(stat_word[FLAG_BIT:0]) && $stable(stat_addr)));

  assert_w1c_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[FLAG_BIT] && !ev_valid) |=> (stat_word == '0));

  assert_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[FLAG_BIT] |-> (stat_word[ORIG_BIT] == (stat_word[CODE_LSB +: 4] > 4'd3)));

  assert_fill_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_in_fail) |-> (rsp_out_data == {DATA_W{1'b1}}));

  assert_valid_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_out_valid == rsp_in_valid);
endmodule

bind bridge_err_status bes_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bes_checker (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .wr_en(wr_en), .wr_data(wr_data),
  .stat_word(stat_word), .stat_addr(stat_addr), .mchk_req(mchk_req),
  .rsp_in_valid(rsp_in_valid), .rsp_in_fail(rsp_in_fail),
  .rsp_out_valid(rsp_out_valid), .rsp_out_data(rsp_out_data)
);

// File: tb/bridge_err_status_bench.sv
module bridge_err_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [3:0]  ev_cmd = '0, ev_code = '0, rsp_in_code = '0;
  logic [31:0] ev_addr = '0, wr_data = '0, rsp_in_data = '0;
  logic        wr_en = 1'b0, rsp_in_valid = 1'b0, rsp_in_fail = 1'b0, rsp_out_ready = 1'b0;
  logic [31:0] stat_word, stat_addr, rsp_out_data;
  logic        mchk_req, rsp_in_ready, rsp_out_valid, rsp_out_alarm;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bridge_err_status u_bridge_err_status (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_cmd(ev_cmd), .ev_code(ev_code),
    .ev_addr(ev_addr), .wr_en(wr_en), .wr_data(wr_data), .stat_word(stat_word),
    .stat_addr(stat_addr), .mchk_req(mchk_req), .rsp_in_valid(rsp_in_valid),
    .rsp_in_ready(rsp_in_ready), .rsp_in_data(rsp_in_data), .rsp_in_fail(rsp_in_fail),
    .rsp_in_code(rsp_in_code), .rsp_out_valid(rsp_out_valid), .rsp_out_ready(rsp_out_ready),
    .rsp_out_data(rsp_out_data), .rsp_out_alarm(rsp_out_alarm)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [3:0] cmd, input logic [3:0] code,
                                           input logic [31:0] addr, input bit lost);
    logic [31:0] w;
    w = {28'd0, cmd} + 32'h10 + (lost ? 32'h20 : 32'h0) + ({28'd0, code} << 8);
    if (code > 3) w = w + 32'h1000;
    if (code == 5 || code == 6) w = w + ((addr >> 13) << 13);
    return w;
  endfunction

  task automatic log_event(input logic [3:0] cmd, input logic [3:0] code, input logic [31:0] addr);
    @(negedge clk);
    ev_valid = 1'b1; ev_cmd = cmd; ev_code = code; ev_addr = addr;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic write_stat(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, w;
    repeat (3) @(negedge clk);
    check("R1 stat_word", stat_word, 32'h0);
    check("R1 stat_addr", stat_addr, 32'h0);
    check("R1 mchk", {31'd0, mchk_req}, 32'h0);
    rst_n = 1'b1;

    // R2 R3 R4 R8 R6: sweep every command against every defined code
    for (int cmd = 0; cmd < 16; cmd++) begin
      for (int code = 0; code < 8; code++) begin
        a = 32'h9E37_79B9 * (cmd * 8 + code + 1);
        log_event(cmd[3:0], code[3:0], a);
        w = exp_word(cmd[3:0], code[3:0], a, 0);
        check("R2 capture word", stat_word, w);
        check("R2 capture addr", stat_addr, a);
        check("R3 origin bit", {31'd0, stat_word[12]}, {31'd0, code > 3});
        check("R4 page field", stat_word & 32'hFFFF_E000,
              (code == 5 || code == 6) ? (a & 32'hFFFF_E000) : 32'h0);
        check("R8 mchk lags flag", {31'd0, mchk_req}, 32'h0);
        @(negedge clk);
        check("R8 mchk raised", {31'd0, mchk_req}, 32'h1);
        write_stat(32'h0000_0010);
        check("R6 clear word", stat_word, 32'h0);
        check("R6 clear addr", stat_addr, 32'h0);
        check("R8 mchk held one more", {31'd0, mchk_req}, 32'h1);
        @(negedge clk);
        check("R8 mchk dropped", {31'd0, mchk_req}, 32'h0);
      end
    end

    // R5: second errors keep the first record and set lost
    log_event(4'hA, 4'd5, 32'h1234_5678);
    w = exp_word(4'hA, 4'd5, 32'h1234_5678, 0);
    log_event(4'h3, 4'd2, 32'hDEAD_BEEF);
    check("R5 first kept, lost set", stat_word, w | 32'h20);
    check("R5 first addr kept", stat_addr, 32'h1234_5678);
    log_event(4'h7, 4'd6, 32'h0F0F_0F0F);
    check("R5 third also dropped", stat_word, w | 32'h20);

    // R6: zero write ignored; lost-only write clears lost only
    write_stat(32'h0000_0000);
    check("R6 zero write no effect", stat_word, w | 32'h20);
    write_stat(32'h0000_0020);
    check("R6 lost-only clear", stat_word, w);
    check("R6 addr after lost clear", stat_addr, 32'h1234_5678);
    log_event(4'h1, 4'd0, 32'h0);
    write_stat(32'h0000_0010);
    check("R6 flag write also clears lost", stat_word, 32'h0);

    // R7: event in the same cycle as a clearing write is captured fresh
    log_event(4'h2, 4'd3, 32'h5555_0000);
    log_event(4'h4, 4'd1, 32'h6666_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_0030;
    ev_valid = 1'b1; ev_cmd = 4'hC; ev_code = 4'd7; ev_addr = 32'hCAFE_0001;
    @(negedge clk);
    wr_en = 1'b0; ev_valid = 1'b0;
    check("R7 fresh capture word", stat_word, exp_word(4'hC, 4'd7, 32'hCAFE_0001, 0));
    check("R7 fresh capture addr", stat_addr, 32'hCAFE_0001);
    write_stat(32'h0000_0030);

    // R9 R10 R11: configuration read responses
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 2; f++) begin
        for (int rdy = 0; rdy < 2; rdy++) begin
          @(negedge clk);
          rsp_in_valid = 1'b1; rsp_out_ready = rdy[0];
          rsp_in_fail = f[0]; rsp_in_code = code[3:0];
          rsp_in_data = 32'h0101_0101 * (code + 1) + f;
          #1;
          check("R9 read data", rsp_out_data, f ? 32'hFFFF_FFFF : rsp_in_data);
          check("R10 alarm", {31'd0, rsp_out_alarm}, {31'd0, (f == 1) && (code != 1)});
          check("R11 ready follows", {31'd0, rsp_in_ready}, {31'd0, rdy[0]});
          check("R11 valid follows", {31'd0, rsp_out_valid}, 32'h1);
        end
      end
    end
    // R11: stalled beat stays unchanged over several cycles
    @(negedge clk);
    rsp_out_ready = 1'b0; rsp_in_fail = 1'b0; rsp_in_data = 32'h0BAD_F00D;
    repeat (3) begin
      @(negedge clk);
      check("R11 stalled data stable", rsp_out_data, 32'h0BAD_F00D);
      check("R11 stalled ready low", {31'd0, rsp_in_ready}, 32'h0);
    end
    rsp_in_valid = 1'b0;
    #1;
    check("R11 valid drop", {31'd0, rsp_out_valid}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule